// File: doc/BRIEF.md
# Watchdog Countdown Timer with Set-Once Mode Bits

This block is a watchdog countdown timer controlled through a small register port. Software arms the timer, then proves it is alive by writing a two-byte key sequence to a feed register. The counter runs down on an external tick enable. If it reaches zero, the block raises a time-out flag. An optional reset-request output turns that flag into a request for a system reset. A warning flag gives software an early notice once the count falls to a programmable threshold.

The mode register holds four control bits: run enable, reset enable, update protect and clock lock. Software can set each of them, but only the asynchronous reset clears them. Run enable and clock lock take effect only at the next valid feed. After that feed the counter cannot be stopped, and the clock-lock output stays asserted. The two status flags are cleared in opposite ways. The warning flag is cleared by writing 1 to its bit, and the time-out flag is cleared by writing 0 to its bit.

Top module: `wdog_sticky`

## Requirements
- R1: After the active-low asynchronous reset, the mode register reads 0, the counter reads all ones, and `warn_irq`, `rst_req` and `clk_lock` are low.
- R2: Mode bits sit at run enable bit 0, reset enable bit 1, time-out flag bit 2, warning flag bit 3, update protect bit 4 and clock lock bit 5. Writing 1 sets run enable, reset enable, update protect and clock lock. A later write of 0 leaves them set.
- R3: A feed-register write of 0xAA followed by a feed-register write of 0x55 is a valid feed. A valid feed loads the counter with `reload_val`, and the new value is readable at counter address 2 after the second write.
- R4: A feed-register write other than 0xAA while no key is pending, or other than 0x55 while 0xAA is pending, is a feed error. A feed error sets the time-out flag.
- R5: The counter decrements by one per cycle with `tick_en` only after run enable is set and a valid feed follows. Before that, ticks leave it unchanged. After it starts, writing 0 to run enable does not stop it.
- R6: A tick while running with the counter at 0 sets the time-out flag, and the counter holds at 0 until the next valid feed.
- R7: Writing 0 to bit 2 of the mode register clears the time-out flag. Writing 1 to bit 2 leaves it unchanged.
- R8: A decrement to a value at or below `warn_thresh` sets the warning flag, which drives `warn_irq`. Writing 1 to bit 3 clears it. Writing 0 to bit 3 leaves it unchanged.
- R9: A write of 1 to bit 3 does not clear the warning flag while the counter equals `warn_thresh`.
- R10: `rst_req` is high exactly when both the time-out flag and reset enable are set.
- R11: `clk_lock` rises at the first valid feed after the clock-lock bit is set. It stays high until reset.
- R12: With update protect set, a change of `reload_val` while the counter is above `warn_thresh` sets the time-out flag. The same change has no effect when the counter is at or below the threshold, or when update protect is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 mode, 1 feed |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address: 0 mode, 2 counter |
| rd_data | output | RD_W | Combinational read data |
| tick_en | input | 1 | Count enable, one decrement per cycle |
| reload_val | input | CNT_W | Value loaded by a valid feed |
| warn_thresh | input | CNT_W | Warning threshold |
| warn_irq | output | 1 | Warning flag output |
| rst_req | output | 1 | Reset request |
| clk_lock | output | 1 | Blocks disabling the watchdog clock |

## Verification
A register write, a feed and a tick each change the state at the rising edge that samples them. Reads are combinational, so every result can be seen one edge after its stimulus. `rst_req` follows the flags with no further delay. A protect violation is registered at the edge after the `reload_val` change, because it is detected against a sampled copy of the reload value. The bench drives every input on the falling edge and reads back at the next falling edge, which is the earliest point where each of these results is due and the point where it is stable.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // mode register bit positions (software visible)
   localparam int MB_RUN    = 0;
   localparam int MB_RST    = 1;
   localparam int MB_TMO    = 2;
   localparam int MB_WARN   = 3;
   localparam int MB_PROT   = 4;
   localparam int MB_LOCK   = 5;
   localparam int MODE_BITS = 6;

   // set-once control bits, enumerated
   localparam int N_STICKY  = 4;

   function automatic int sticky_pos(input int idx);
      case (idx)
         0:       return MB_RUN;
         1:       return MB_RST;
         2:       return MB_PROT;
         default: return MB_LOCK;
      endcase
   endfunction

   typedef enum logic [0:0] {
      FEED_IDLE  = 1'b0,
      FEED_ARMED = 1'b1
   } feed_state_t;

   typedef struct packed {
      logic ok;
      logic err;
   } feed_evt_t;

endpackage

// File: rtl/wdog_feed_seq.sv
module wdog_feed_seq
   import wdog_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hAA,
   parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              feed_wr,
   input  logic [DATA_W-1:0] feed_data,
   output feed_evt_t         evt
);

   feed_state_t st_q, st_d;

   always_comb begin
      st_d    = st_q;
      evt.ok  = 1'b0;
      evt.err = 1'b0;
      if (feed_wr) begin
         case (st_q)
            FEED_IDLE: begin
               if (feed_data == KEY_FIRST) st_d = FEED_ARMED;
               else                        evt.err = 1'b1;
            end
            default: begin
               st_d = FEED_IDLE;
               if (feed_data == KEY_SECOND) evt.ok  = 1'b1;
               else                         evt.err = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= FEED_IDLE;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             running,
   input  logic             tick_en,
   input  logic             feed_ok,
   input  logic             prot_en,
   input  logic [CNT_W-1:0] reload_val,
   input  logic [CNT_W-1:0] warn_thresh,
   output logic [CNT_W-1:0] cnt,
   output logic             tmo_evt,
   output logic             warn_evt,
   output logic             prot_evt,
   output logic             at_thresh
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q, cnt_dec, reload_q;
   logic             tick_live, is_zero, dec_fire;

   assign tick_live = running & tick_en & ~feed_ok;
   assign is_zero   = (cnt_q == '0);
   assign dec_fire  = tick_live & ~is_zero;
   assign cnt_dec   = cnt_q - CNT_ONE;

   assign tmo_evt   = tick_live & is_zero;
   assign warn_evt  = dec_fire & (cnt_dec <= warn_thresh);
   assign prot_evt  = prot_en & (reload_val != reload_q) & (cnt_q > warn_thresh);
   assign at_thresh = (cnt_q == warn_thresh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_MAX;
      end else if (feed_ok) begin
         cnt_q <= reload_val;
      end else if (dec_fire) begin
         cnt_q <= cnt_dec;
      end
   end

   // sampled copy of the reload constant, used to spot changes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reload_q <= '0;
      else        reload_q <= reload_val;
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/wdog_mode_regs.sv
module wdog_mode_regs
   import wdog_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_wr,
   input  logic [MODE_BITS-1:0] wdata,
   input  logic                 feed_ok,
   input  logic                 tmo_set,
   input  logic                 warn_set,
   input  logic                 warn_hold,
   output logic                 run_en,
   output logic                 rst_en,
   output logic                 prot_en,
   output logic                 lock_en,
   output logic                 running,
   output logic                 clk_lock,
   output logic                 tmo_flag,
   output logic                 warn_flag,
   output logic [MODE_BITS-1:0] mode_word
);

   logic [N_STICKY-1:0] sticky_q;
   logic                tmo_q, warn_q, run_q, lock_q;
   logic                clr_tmo, clr_warn;

   // set-once control bits: only reset clears them
   for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
      localparam int POS = sticky_pos(i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       sticky_q[i] <= 1'b0;
         else if (mode_wr && wdata[POS])   sticky_q[i] <= 1'b1;
      end
   end

   assign run_en  = sticky_q[0];
   assign rst_en  = sticky_q[1];
   assign prot_en = sticky_q[2];
   assign lock_en = sticky_q[3];

   // bits that take effect only at a valid feed
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         lock_q <= 1'b0;
      end else if (feed_ok) begin
         run_q  <= run_q  | run_en;
         lock_q <= lock_q | lock_en;
      end
   end

   // flags: set events win over a clear in the same cycle
   assign clr_tmo  = mode_wr & ~wdata[MB_TMO];
   assign clr_warn = mode_wr &  wdata[MB_WARN] & ~warn_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo_q  <= 1'b0;
         warn_q <= 1'b0;
      end else begin
         tmo_q  <= tmo_set  | (tmo_q  & ~clr_tmo);
         warn_q <= warn_set | (warn_q & ~clr_warn);
      end
   end

   assign running   = run_q;
   assign clk_lock  = lock_q;
   assign tmo_flag  = tmo_q;
   assign warn_flag = warn_q;

   always_comb begin
      mode_word          = '0;
      mode_word[MB_RUN]  = run_en;
      mode_word[MB_RST]  = rst_en;
      mode_word[MB_TMO]  = tmo_q;
      mode_word[MB_WARN] = warn_q;
      mode_word[MB_PROT] = prot_en;
      mode_word[MB_LOCK] = lock_en;
   end

endmodule

// File: rtl/wdog_sticky.sv
module wdog_sticky
   import wdog_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 2,
   parameter int MODE_ADDR = 0,
   parameter int FEED_ADDR = 1,
   parameter int CNT_ADDR  = 2,
   parameter bit CNT_READ  = 1'b1,
   parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hAA,
   parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55,
   localparam int RD_W = (CNT_W > DATA_W) ? CNT_W : DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [RD_W-1:0]   rd_data,
   input  logic              tick_en,
   input  logic [CNT_W-1:0]  reload_val,
   input  logic [CNT_W-1:0]  warn_thresh,
   output logic              warn_irq,
   output logic              rst_req,
   output logic              clk_lock
);

   // elaboration-time parameter checks
   if (CNT_W < 2)
      $error("wdog_sticky: CNT_W must be at least 2");
   if (DATA_W < MODE_BITS)
      $error("wdog_sticky: DATA_W must hold the mode bits");
   if (MODE_ADDR == FEED_ADDR || MODE_ADDR == CNT_ADDR || FEED_ADDR == CNT_ADDR)
      $error("wdog_sticky: register addresses must differ");
   if (MODE_ADDR >= (1 << ADDR_W) || FEED_ADDR >= (1 << ADDR_W) || CNT_ADDR >= (1 << ADDR_W))
      $error("wdog_sticky: address out of range for ADDR_W");
   if (KEY_FIRST == KEY_SECOND)
      $error("wdog_sticky: feed keys must differ");

   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(MODE_ADDR);
   localparam logic [ADDR_W-1:0] A_FEED = ADDR_W'(FEED_ADDR);
   localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(CNT_ADDR);

   logic                 mode_wr, feed_wr;
   feed_evt_t            fevt;
   logic                 feed_ok, feed_err;
   logic [CNT_W-1:0]     cnt;
   logic                 tmo_evt, warn_evt, prot_evt, at_thresh;
   logic                 run_en, rst_en, prot_en, lock_en, running;
   logic                 tmo_flag, warn_flag;
   logic [MODE_BITS-1:0] mode_word;
   logic [CNT_W-1:0]     cnt_view;

   assign mode_wr = wr_en & (wr_addr == A_MODE);
   assign feed_wr = wr_en & (wr_addr == A_FEED);

   wdog_feed_seq #(
      .DATA_W     (DATA_W),
      .KEY_FIRST  (KEY_FIRST),
      .KEY_SECOND (KEY_SECOND)
   ) u_feed (
      .clk       (clk),
      .rst_n     (rst_n),
      .feed_wr   (feed_wr),
      .feed_data (wr_data),
      .evt       (fevt)
   );

   assign feed_ok  = fevt.ok;
   assign feed_err = fevt.err;

   wdog_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .running     (running),
      .tick_en     (tick_en),
      .feed_ok     (feed_ok),
      .prot_en     (prot_en),
      .reload_val  (reload_val),
      .warn_thresh (warn_thresh),
      .cnt         (cnt),
      .tmo_evt     (tmo_evt),
      .warn_evt    (warn_evt),
      .prot_evt    (prot_evt),
      .at_thresh   (at_thresh)
   );

   wdog_mode_regs u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_wr   (mode_wr),
      .wdata     (wr_data[MODE_BITS-1:0]),
      .feed_ok   (feed_ok),
      .tmo_set   (tmo_evt | feed_err | prot_evt),
      .warn_set  (warn_evt),
      .warn_hold (at_thresh),
      .run_en    (run_en),
      .rst_en    (rst_en),
      .prot_en   (prot_en),
      .lock_en   (lock_en),
      .running   (running),
      .clk_lock  (clk_lock),
      .tmo_flag  (tmo_flag),
      .warn_flag (warn_flag),
      .mode_word (mode_word)
   );

   // counter read-back variant
   if (CNT_READ) begin : g_cnt_rd
      assign cnt_view = cnt;
   end else begin : g_cnt_hide
      assign cnt_view = '0;
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_MODE)     rd_data[MODE_BITS-1:0] = mode_word;
      else if (rd_addr == A_CNT) rd_data[CNT_W-1:0]     = cnt_view;
   end

   assign warn_irq = warn_flag;
   assign rst_req  = tmo_flag & rst_en;

endmodule

// File: rtl/wdog_sticky_chk.sv
module wdog_sticky_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic [CNT_W-1:0] reload_val,
   input logic [CNT_W-1:0] warn_thresh,
   input logic [CNT_W-1:0] cnt,
   input logic             running,
   input logic             feed_ok,
   input logic             feed_err,
   input logic             tmo_flag,
   input logic             warn_flag,
   input logic             run_en,
   input logic             rst_en,
   input logic             prot_en,
   input logic             lock_en,
   input logic             clk_lock
);

   assert_run_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |=> run_en);
   assert_rst_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_en |=> rst_en);
   assert_prot_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      prot_en |=> prot_en);
   assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lock_en |=> lock_en);
   assert_feed_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      feed_ok |=> (cnt == $past(reload_val)));
   assert_feed_err_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      feed_err |=> tmo_flag);
   assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !feed_ok) |=> $stable(cnt));
   assert_running_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      running |=> running);
   assert_timeout_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (running && tick_en && cnt == '0 && !feed_ok) |=> tmo_flag);
   assert_hold_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (running && cnt == '0 && !feed_ok) |=> (cnt == '0));
   assert_warn_stuck_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (warn_flag && cnt == warn_thresh) |=> warn_flag);
   assert_lock_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      clk_lock |=> clk_lock);

endmodule

bind wdog_sticky wdog_sticky_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_en     (tick_en),
   .reload_val  (reload_val),
   .warn_thresh (warn_thresh),
   .cnt         (cnt),
   .running     (running),
   .feed_ok     (feed_ok),
   .feed_err    (feed_err),
   .tmo_flag    (tmo_flag),
   .warn_flag   (warn_flag),
   .run_en      (run_en),
   .rst_en      (rst_en),
   .prot_en     (prot_en),
   .lock_en     (lock_en),
   .clk_lock    (clk_lock)
);

// File: tb/wdog_sticky_test.sv
module wdog_sticky_test;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W  = 16;
   localparam int DATA_W = 8;
   localparam int ADDR_W = 2;
   localparam int RD_W   = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [RD_W-1:0]   rd_data;
   logic              tick_en = 1'b0;
   logic [CNT_W-1:0]  reload_val = 16'd100;
   logic [CNT_W-1:0]  warn_thresh = 16'd10;
   logic              warn_irq, rst_req, clk_lock;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdog_sticky uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data),
      .tick_en     (tick_en),
      .reload_val  (reload_val),
      .warn_thresh (warn_thresh),
      .warn_irq    (warn_irq),
      .rst_req     (rst_req),
      .clk_lock    (clk_lock)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; tick_en = 1'b0;
      reload_val = 16'd100; warn_thresh = 16'd10;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic feed();
      wr(2'd1, 8'hAA);
      wr(2'd1, 8'h55);
   endtask

   task automatic tick(input int n);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [RD_W-1:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic t_reset();
      logic [RD_W-1:0] v;
      do_reset();
      rd(2'd0, v); chk("R1 mode after reset", v, 0);
      rd(2'd2, v); chk("R1 counter after reset", v, 16'hFFFF);
      chk("R1 outputs after reset", {warn_irq, rst_req, clk_lock}, 0);
   endtask

   task automatic t_sticky();
      logic [RD_W-1:0] v;
      do_reset();
      wr(2'd0, 8'h33);
      rd(2'd0, v); chk("R2 set bits", v, 16'h33);
      wr(2'd0, 8'h00);
      rd(2'd0, v); chk("R2 zero write ignored", v, 16'h33);
   endtask

   task automatic t_feed_run();
      logic [RD_W-1:0] v;
      do_reset();
      reload_val = 16'd20;
      feed();
      rd(2'd2, v); chk("R3 feed reload", v, 20);
      tick(5);
      rd(2'd2, v); chk("R5 no count without run", v, 20);
      wr(2'd0, 8'h01);
      tick(3);
      rd(2'd2, v); chk("R5 no count before feed", v, 20);
      feed();
      tick(3);
      rd(2'd2, v); chk("R5 counting", v, 17);
      wr(2'd0, 8'h00);
      tick(2);
      rd(2'd2, v); chk("R5 cannot stop", v, 15);
   endtask

   task automatic t_feed_err();
      logic [RD_W-1:0] v;
      do_reset();
      wr(2'd1, 8'h12);
      rd(2'd0, v); chk("R4 bad first key", v[2], 1);
      wr(2'd0, 8'h04);
      rd(2'd0, v); chk("R7 write 1 keeps tmo", v[2], 1);
      wr(2'd0, 8'h00);
      rd(2'd0, v); chk("R7 write 0 clears tmo", v[2], 0);
      wr(2'd1, 8'hAA);
      wr(2'd1, 8'hAA);
      rd(2'd0, v); chk("R4 bad second key", v[2], 1);
      wr(2'd0, 8'h00);
      reload_val = 16'd7;
      feed();
      rd(2'd0, v); chk("R4 good feed no error", v[2], 0);
      rd(2'd2, v); chk("R3 reload after recovery", v, 7);
   endtask

   task automatic t_timeout();
      logic [RD_W-1:0] v;
      do_reset();
      reload_val = 16'd3;
      wr(2'd0, 8'h01);
      feed();
      tick(3);
      rd(2'd2, v); chk("R6 reached zero", v, 0);
      rd(2'd0, v); chk("R6 no timeout yet", v[2], 0);
      tick(1);
      rd(2'd0, v); chk("R6 timeout flag", v[2], 1);
      chk("R10 no request without rst_en", rst_req, 0);
      wr(2'd0, 8'h06);
      chk("R10 request", rst_req, 1);
      wr(2'd0, 8'h02);
      chk("R10 request drops on clear", rst_req, 0);
      tick(2);
      rd(2'd2, v); chk("R6 counter held at zero", v, 0);
      chk("R10 request again", rst_req, 1);
   endtask

   task automatic t_warn();
      logic [RD_W-1:0] v;
      do_reset();
      warn_thresh = 16'd4; reload_val = 16'd6;
      wr(2'd0, 8'h01);
      feed();
      tick(1);
      chk("R8 above threshold", warn_irq, 0);
      tick(1);
      chk("R8 at threshold sets", warn_irq, 1);
      wr(2'd0, 8'h09);
      chk("R9 clear blocked at threshold", warn_irq, 1);
      tick(1);
      wr(2'd0, 8'h01);
      chk("R8 write 0 keeps warn", warn_irq, 1);
      wr(2'd0, 8'h09);
      chk("R8 write 1 clears", warn_irq, 0);
      do_reset();
      warn_thresh = 16'd0; reload_val = 16'd2;
      wr(2'd0, 8'h01);
      feed();
      tick(2);
      chk("R8 zero threshold sets", warn_irq, 1);
      wr(2'd0, 8'h09);
      chk("R9 stuck at zero", warn_irq, 1);
   endtask

   task automatic t_lock();
      logic [RD_W-1:0] v;
      do_reset();
      wr(2'd0, 8'h20);
      chk("R11 no lock before feed", clk_lock, 0);
      feed();
      chk("R11 lock after feed", clk_lock, 1);
      wr(2'd0, 8'h00);
      rd(2'd0, v); chk("R2 lock bit kept", v[5], 1);
      chk("R11 lock held", clk_lock, 1);
   endtask

   task automatic t_protect();
      logic [RD_W-1:0] v;
      do_reset();
      reload_val = 16'd15;
      @(negedge clk);
      @(negedge clk);
      rd(2'd0, v); chk("R12 no effect without protect", v[2], 0);
      warn_thresh = 16'd4; reload_val = 16'd10;
      wr(2'd0, 8'h10);
      feed();
      rd(2'd0, v); chk("R12 setup clean", v[2], 0);
      reload_val = 16'd11;
      @(negedge clk);
      rd(2'd0, v); chk("R12 violation above threshold", v[2], 1);
      wr(2'd0, 8'h11);
      feed();
      tick(7);
      rd(2'd2, v); chk("R12 counter at threshold", v, 4);
      reload_val = 16'd12;
      @(negedge clk);
      @(negedge clk);
      rd(2'd0, v); chk("R12 no violation at threshold", v[2], 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_sticky();
      t_feed_run();
      t_feed_err();
      t_timeout();
      t_warn();
      t_lock();
      t_protect();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule